// File: doc/BRIEF.md
# Single-Cycle 16-bit Register-Pair Processor Core

This block is a small processor core that executes one instruction per clock. It holds two 16-bit registers: an address register and a data register. It also holds a 15-bit program counter. The instruction memory and the data memory sit outside the core. The core presents an instruction address and a data address to them. In the same cycle it takes back the instruction word and the memory read data.

Each instruction word is one of two kinds. The top bit selects the kind. An address-load word copies itself into the address register. A compute word does three things:
- It drives an ALU with six conditioning and function bits. The first operand is the data register. The second operand is either the address register or the memory read data.
- It writes the ALU result to any mix of three destinations: the address register, the data register, and memory.
- It can replace the program-counter increment with a jump to the address register. The jump is taken when the sign and zero of the result match the enabled conditions.

Top module: `regcpu_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the address register and the data register on the next rising edge. `rst` overrides any jump.
- R2: When `instr[15]` is 0 (address-load), the next rising edge loads the whole instruction word into the address register. `data_addr` then shows `instr[14:0]`.
- R3: When `instr[15]` is 1 (compute) and `instr[5]` is 1, the next rising edge loads the ALU result into the address register. When `instr[15]` is 1 and `instr[5]` is 0, the address register holds its value.
- R4: The data register loads the ALU result only when `instr[15]` is 1 and `instr[4]` is 1. Otherwise it holds its value.
- R5: `mem_we` is high exactly when `instr[15]` is 1 and `instr[3]` is 1. `mem_wdata` always carries the current ALU result. Both are combinational.
- R6: The ALU's first operand is always the data register. Its second operand is `mem_rdata` when `instr[15]` and `instr[12]` are both 1, and the address register otherwise.
- R7: The ALU control bits are `instr[11]` through `instr[6]`.
  - `instr[11]` zeroes the first operand and `instr[10]` then inverts it.
  - `instr[9]` zeroes the second operand and `instr[8]` then inverts it.
  - `instr[7]` selects the function: 1 is add, 0 is bitwise AND.
  - `instr[6]` inverts the result.
- R8: For a compute word, the program counter loads the address register's current low 15 bits in three cases:
  - `instr[2]` is set and the result is negative (MSB = 1).
  - `instr[1]` is set and the result is zero.
  - `instr[0]` is set and the result is neither negative nor zero.
- R9: When neither reset nor a jump applies, the program counter increments by one and wraps at 15 bits. `instr_addr` shows the program counter and `data_addr` shows the low 15 bits of the address register.
- R10: An address-load word never asserts `mem_we`, never changes the data register and never jumps, whatever its low bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Data memory read data for `data_addr` |
| instr | input | 16 | Instruction word fetched from `instr_addr` |
| mem_wdata | output | 16 | ALU result, the data to write to memory |
| mem_we | output | 1 | Memory write strobe for `data_addr` |
| data_addr | output | 15 | Low 15 bits of the address register |
| instr_addr | output | 15 | Program counter |

## Verification
The bench builds the core with its default widths: a 16-bit datapath and a 15-bit program counter. With these widths, random compute words reach every combination of the six ALU control bits. The operands are random 16-bit values, so carries, sign changes and exact-zero results all occur. Random jump targets spread the program counter across the full 15-bit range, and the increment wrap at the top of that range becomes reachable. Reset pulses land on arbitrary cycles, including cycles whose instruction would take a jump.

// File: rtl/regcpu_pkg.sv
package regcpu_pkg;
  localparam int INSTR_W   = 16;
  localparam int KIND_BIT  = 15;
  localparam int YSEL_BIT  = 12;
  localparam int CTRL_MSB  = 11;
  localparam int CTRL_W    = 6;
  localparam int DST_A_BIT = 5;
  localparam int DST_D_BIT = 4;
  localparam int DST_M_BIT = 3;
  localparam int JLT_BIT   = 2;
  localparam int JEQ_BIT   = 1;
  localparam int JGT_BIT   = 0;

  typedef struct packed {
    logic clr_x;
    logic inv_x;
    logic clr_y;
    logic inv_y;
    logic sum;
    logic inv_o;
  } alu_ctrl_t;

  typedef struct packed {
    logic      comp;
    logic      ld_a;
    logic      ld_d;
    logic      wr_mem;
    logic      y_mem;
    alu_ctrl_t ctrl;
    logic      c_lt;
    logic      c_eq;
    logic      c_gt;
  } dec_t;
endpackage

// File: rtl/regcpu_decode.sv
module regcpu_decode
  import regcpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic comp;
  assign comp = instr[KIND_BIT];

  always_comb begin
    dec.comp   = comp;
    dec.ld_a   = ~comp | instr[DST_A_BIT];
    dec.ld_d   = comp & instr[DST_D_BIT];
    dec.wr_mem = comp & instr[DST_M_BIT];
    dec.y_mem  = comp & instr[YSEL_BIT];
    dec.ctrl   = alu_ctrl_t'(instr[CTRL_MSB -: CTRL_W]);
    dec.c_lt   = comp & instr[JLT_BIT];
    dec.c_eq   = comp & instr[JEQ_BIT];
    dec.c_gt   = comp & instr[JGT_BIT];
  end
endmodule

// File: rtl/regcpu_alu.sv
module regcpu_alu
  import regcpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_ctrl_t    ctrl,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         neg
);
  logic [W-1:0] xz, xc, yz, yc, raw;

  always_comb begin
    xz  = ctrl.clr_x ? '0 : x;
    xc  = ctrl.inv_x ? ~xz : xz;
    yz  = ctrl.clr_y ? '0 : y;
    yc  = ctrl.inv_y ? ~yz : yz;
    raw = ctrl.sum ? (xc + yc) : (xc & yc);
    res = ctrl.inv_o ? ~raw : raw;
  end

  assign zero = (res == '0);
  assign neg  = res[W-1];
endmodule

// File: rtl/regcpu_pc.sv
module regcpu_pc #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_lt,
  input  logic              c_eq,
  input  logic              c_gt,
  input  logic              zero,
  input  logic              neg,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  logic              take;
  logic [ADDR_W-1:0] pc_q;

  assign take = (c_lt & neg) | (c_eq & zero) | (c_gt & ~neg & ~zero);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (take) pc_q <= target;
    else           pc_q <= pc_q + 1'b1;
  end

  assign pc = pc_q;

  // R1
  pc_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc_q == '0);
  // R8
  pc_jmp_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take)) |-> pc_q == $past(target));
  // R9
  pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(take)) |-> pc_q == $past(pc_q) + 1'b1);
  // R8
  pc_gt_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (c_gt && !c_lt && !c_eq && neg) |=> pc_q == $past(pc_q) + 1'b1);
endmodule

// File: rtl/regcpu_core.sv
module regcpu_core
  import regcpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [INSTR_W-1:0] instr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] data_addr,
  output logic [ADDR_W-1:0] instr_addr
);
  dec_t              dec;
  logic [DATA_W-1:0] a_q, d_q, a_in, y_op, alu_res;
  logic              alu_zero, alu_neg;

  regcpu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign y_op = dec.y_mem ? mem_rdata : a_q;

  regcpu_alu #(.W(DATA_W)) u_alu (
    .x    (d_q),
    .y    (y_op),
    .ctrl (dec.ctrl),
    .res  (alu_res),
    .zero (alu_zero),
    .neg  (alu_neg)
  );

  assign a_in = dec.comp ? alu_res : DATA_W'(instr);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      d_q <= '0;
    end else begin
      if (dec.ld_a) a_q <= a_in;
      if (dec.ld_d) d_q <= alu_res;
    end
  end

  regcpu_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .c_lt   (dec.c_lt),
    .c_eq   (dec.c_eq),
    .c_gt   (dec.c_gt),
    .zero   (alu_zero),
    .neg    (alu_neg),
    .target (a_q[ADDR_W-1:0]),
    .pc     (instr_addr)
  );

  assign mem_wdata = alu_res;
  assign mem_we    = dec.wr_mem;
  assign data_addr = a_q[ADDR_W-1:0];

  // R10
  addr_kind_we_chk: assert property (@(posedge clk) disable iff (rst)
    !instr[KIND_BIT] |-> !mem_we);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(instr[KIND_BIT])) |-> data_addr == $past(instr[ADDR_W-1:0]));
  // R4
  d_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dec.ld_d)) |-> $stable(d_q));
  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[KIND_BIT]) && !$past(instr[DST_A_BIT])) |-> $stable(a_q));
endmodule

// File: tb/regcpu_core_bench.sv
module regcpu_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata = '0;
  logic [15:0] instr = '0;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [14:0] data_addr, instr_addr;

  int unsigned vectors = 0;
  int unsigned misses  = 0;
  logic [15:0] ma, md;
  logic [14:0] mpc;
  logic [15:0] ram [64];

  always #4ns clk = ~clk;

  regcpu_core u_regcpu_core (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .instr(instr),
    .mem_wdata(mem_wdata), .mem_we(mem_we),
    .data_addr(data_addr), .instr_addr(instr_addr)
  );

  function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                          input logic [5:0] c);
    logic [15:0] xv, yv, o;
    xv = c[5] ? 16'h0 : x;
    xv = c[4] ? ~xv : xv;
    yv = c[3] ? 16'h0 : y;
    yv = c[2] ? ~yv : yv;
    o  = c[1] ? xv + yv : xv & yv;
    return c[0] ? ~o : o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic r);
    logic [15:0] y, res;
    logic        comp, jmp;
    @(negedge clk);
    instr     = w;
    rst       = r;
    mem_rdata = ram[ma[5:0]];
    #1;
    comp = w[15];
    y    = (comp && w[12]) ? mem_rdata : ma;
    res  = ref_alu(md, y, w[11:6]);
    chk("R7 R6 R4 wdata", {16'h0, mem_wdata}, {16'h0, res});
    chk("R5 R10 we", {31'h0, mem_we}, {31'h0, comp & w[3]});
    chk("R2 R3 R9 daddr", {17'h0, data_addr}, {17'h0, ma[14:0]});
    chk("R9 R8 R1 iaddr", {17'h0, instr_addr}, {17'h0, mpc});
    jmp = comp && ((w[2] && res[15]) || (w[1] && res == 16'h0) ||
                   (w[0] && !res[15] && res != 16'h0));
    if (r) begin
      ma = '0; md = '0; mpc = '0;
    end else begin
      if (comp && w[3]) ram[ma[5:0]] = res;
      mpc = jmp ? ma[14:0] : mpc + 15'd1;
      if (!comp) ma = w;
      else if (w[5]) ma = res;
      if (comp && w[4]) md = res;
    end
  endtask

  initial begin
    #(8ns * 200000);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) ram[i] = 16'(i * 3);
    ma = '0; md = '0; mpc = '0;
    step(16'h0000, 1'b1);
    step(16'h0000, 1'b1);
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 rst pc", {17'h0, instr_addr}, 32'h0);
    chk("R1 rst a", {17'h0, data_addr}, 32'h0);
    // directed program
    step(16'h0005, 1'b0);              // R2 A=5
    step(16'hEC10, 1'b0);              // R4 D=A
    step(16'h0007, 1'b0);              // A=7
    step(16'hE088, 1'b0);              // R5 M=D+A
    step(16'hFC10, 1'b0);              // R6 D=M
    step(16'h0002, 1'b0);              // A=2
    step(16'hE301, 1'b0);              // R8 D;JGT taken
    step(16'h0000, 1'b0);
    step(16'hEA87, 1'b0);              // R8 0;JMP
    step(16'hEE90, 1'b0);              // D=-1
    step(16'h0010, 1'b0);
    step(16'hE304, 1'b0);              // R8 D;JLT taken
    step(16'hE302, 1'b0);              // JEQ not taken
    step(16'h0013, 1'b0);
    step(16'h7FFF, 1'b0);              // R10 address-load with low bits set
    step(16'hEA87, 1'b1);              // R1 reset beats jump
    step(16'h7FFF, 1'b0);
    step(16'hEA87, 1'b0);              // R9 jump to top of range
    step(16'hEA80, 1'b0);              // R9 wrap
    step(16'hEA80, 1'b0);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      step(w, ($urandom % 16) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule